// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration

This block is a synchronous shared memory of 8192 words, 9 bits each (the word width is a package constant, so an 8-bit build is a one-line change). It has two equal ports, left and right. Each port has its own address, write data, chip enable, write select and output enable, so the two sides can read and write at the same time without waiting on each other. Both sides may read the same word in one cycle with no conflict.

A conflict arises when both enabled ports target one address and at least one of them writes. In that case one port is blocked and sees its BUSY flag raised. The port that was already holding the address wins. If both arrive in the same cycle, the left port wins. A blocked write is thrown away. A blocked read still returns the word as stored.

A mode input picks master or slave behaviour. In master mode the local arbiter drives the BUSY outputs. In slave mode the BUSY outputs stay low and the BUSY inputs block the ports instead. This lets several copies be placed side by side for a wider word, with only one of them making the arbitration decision.

Top module: `dual_port_arb_ram`

## Requirements
- R1: After synchronous reset, both read data outputs and both BUSY outputs are zero.
- R2: A write (chip enable high, write select high) that is not blocked stores its data at its address. A read (chip enable high, write select low) returns the stored word on that port's read data output one clock after the access edge.
- R3: When both ports read the same address in one cycle, neither BUSY output rises and both ports get the stored word.
- R4: In master mode, if both enabled ports target the same address, at least one of them writes, and neither was already holding it, the left port wins and only the right BUSY output is high in that cycle. Both BUSY outputs are never high together.
- R5: A port holds an address when it accessed that address in the previous cycle without being blocked. If the right port holds the address and the left port newly arrives with a clashing access, the left BUSY output is high. It stays high for as long as the right port keeps holding the address.
- R6: A write from a blocked port leaves memory unchanged.
- R7: A blocked read returns the word stored before that clock edge, one cycle later, as any read does.
- R8: A port whose chip enable is low makes no access. Its BUSY output stays low and it cannot block the other port.
- R9: Read data is nonzero only in the cycle after an edge where that port had chip enable high, write select low and output enable high. Otherwise it is zero.
- R10: In slave mode (mode input low) both BUSY outputs are zero, and a high BUSY input blocks that port exactly as a raised BUSY does in master mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_i | input | 1 | 1 = master (local arbitration), 0 = slave (external BUSY) |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write select (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 13 | Left word address |
| l_wdata | input | 9 | Left write data |
| l_rdata | output | 9 | Left read data, registered |
| l_busy_i | input | 1 | Left BUSY input, used in slave mode |
| l_busy_o | output | 1 | Left BUSY output, driven in master mode |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write select (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 13 | Right word address |
| r_wdata | input | 9 | Right write data |
| r_rdata | output | 9 | Right read data, registered |
| r_busy_i | input | 1 | Right BUSY input, used in slave mode |
| r_busy_o | output | 1 | Right BUSY output, driven in master mode |

## Verification
The key overlap is an address collision and a storage access in the same cycle. One port writes while the other reads or writes the same word, so the arbitration decision and the write or read have to settle on the same clock edge. The bench provokes this with simultaneous arrivals, where left must win. It also lets the right port hold a word and then brings the left port in against it for two cycles, so that seniority must beat the fixed priority. A behavioural reference model judges every cycle. It compares both BUSY flags before the edge and both read data outputs after it, so a discarded write, or a blocked read that returns the old word, shows up at the ports.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NPORT  = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // Per-port request after decode
    typedef struct packed {
        logic  act;    // port is making an access
        logic  wr;     // access is a write
        logic  drive;  // read result should be presented
        logic  held;   // port already owns this address
        addr_t addr;
        word_t wdata;
    } port_req_t;

    function automatic logic clash(input port_req_t a, input port_req_t b);
        return a.act && b.act && (a.addr == b.addr) && (a.wr || b.wr);
    endfunction
endpackage

// File: rtl/dpr_port_track.sv
module dpr_port_track
    import dpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce,
    input  logic      we,
    input  logic      oe,
    input  addr_t     addr,
    input  word_t     wdata,
    input  logic      blk,
    output port_req_t req
);
    logic  last_act;
    logic  last_blk;
    addr_t last_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_act  <= 1'b0;
            last_blk  <= 1'b0;
            last_addr <= '0;
        end else begin
            last_act  <= ce;
            last_blk  <= blk;
            last_addr <= addr;
        end
    end

    always_comb begin
        req.act   = ce;
        req.wr    = ce & we;
        req.drive = ce & ~we & oe;
        req.held  = ce & last_act & ~last_blk & (addr == last_addr);
        req.addr  = addr;
        req.wdata = wdata;
    end
endmodule

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
(
    input  logic      master_i,
    input  port_req_t req_l,
    input  port_req_t req_r,
    input  logic      ext_busy_l,
    input  logic      ext_busy_r,
    output logic      blk_l,
    output logic      blk_r,
    output logic      busy_l,
    output logic      busy_r
);
    logic hit;
    logic lose_l;
    logic lose_r;

    always_comb begin
        hit    = clash(req_l, req_r);
        // seniority first, left priority on a tie
        lose_l = hit & req_r.held & ~req_l.held;
        lose_r = hit & ~lose_l;
        busy_l = master_i & lose_l;
        busy_r = master_i & lose_r;
        blk_l  = master_i ? lose_l : ext_busy_l;
        blk_r  = master_i ? lose_r : ext_busy_r;
    end
endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
    import dpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  port_req_t req   [NPORT],
    input  logic      blk   [NPORT],
    output word_t     rdata [NPORT]
);
    word_t mem [DEPTH];
    word_t q     [NPORT];
    logic  shown [NPORT];

    // right written first so left lands last if both are let through
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (req[p].wr && !blk[p]) begin
                mem[req[p].addr] <= req[p].wdata;
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                q[p]     <= '0;
                shown[p] <= 1'b0;
            end else begin
                shown[p] <= req[p].drive;
                if (req[p].drive) begin
                    q[p] <= mem[req[p].addr];
                end
            end
        end
        assign rdata[p] = shown[p] ? q[p] : '0;
    end
endmodule

// File: rtl/dual_port_arb_ram.sv
module dual_port_arb_ram
    import dpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_i,
    input  logic              l_ce,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_i,
    output logic              l_busy_o,
    input  logic              r_ce,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_i,
    output logic              r_busy_o
);
    localparam int LP = 0;
    localparam int RP = 1;

    logic      ce_v [NPORT];
    logic      we_v [NPORT];
    logic      oe_v [NPORT];
    addr_t     ad_v [NPORT];
    word_t     wd_v [NPORT];
    port_req_t req  [NPORT];
    logic      blk  [NPORT];
    word_t     rd_v [NPORT];

    always_comb begin
        ce_v[LP] = l_ce;    ce_v[RP] = r_ce;
        we_v[LP] = l_we;    we_v[RP] = r_we;
        oe_v[LP] = l_oe;    oe_v[RP] = r_oe;
        ad_v[LP] = l_addr;  ad_v[RP] = r_addr;
        wd_v[LP] = l_wdata; wd_v[RP] = r_wdata;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpr_port_track u_track (
            .clk   (clk),
            .rst   (rst),
            .ce    (ce_v[p]),
            .we    (we_v[p]),
            .oe    (oe_v[p]),
            .addr  (ad_v[p]),
            .wdata (wd_v[p]),
            .blk   (blk[p]),
            .req   (req[p])
        );
    end

    dpr_arbiter u_arb (
        .master_i   (master_i),
        .req_l      (req[LP]),
        .req_r      (req[RP]),
        .ext_busy_l (l_busy_i),
        .ext_busy_r (r_busy_i),
        .blk_l      (blk[LP]),
        .blk_r      (blk[RP]),
        .busy_l     (l_busy_o),
        .busy_r     (r_busy_o)
    );

    dpr_storage u_mem (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .blk   (blk),
        .rdata (rd_v)
    );

    assign l_rdata = rd_v[LP];
    assign r_rdata = rd_v[RP];
endmodule

// File: rtl/dpr_checks.sv
module dpr_checks
    import dpr_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        master_i,
    input logic        l_ce,
    input logic        l_we,
    input logic        l_oe,
    input addr_t       l_addr,
    input word_t       l_rdata,
    input logic        l_busy_o,
    input logic        r_ce,
    input logic        r_we,
    input logic        r_oe,
    input addr_t       r_addr,
    input word_t       r_rdata,
    input logic        r_busy_o
);
    a_r4_single_loser: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_o && r_busy_o));

    a_r4_clash_flagged: assert property (@(posedge clk) disable iff (rst)
        (master_i && l_ce && r_ce && (l_addr == r_addr) && (l_we || r_we))
        |-> (l_busy_o || r_busy_o));

    a_r3_reads_quiet: assert property (@(posedge clk) disable iff (rst)
        (l_ce && !l_we && r_ce && !r_we) |-> (!l_busy_o && !r_busy_o));

    a_r8_idle_left: assert property (@(posedge clk) disable iff (rst)
        !l_ce |-> (!l_busy_o && !r_busy_o));

    a_r8_idle_right: assert property (@(posedge clk) disable iff (rst)
        !r_ce |-> (!r_busy_o && !l_busy_o));

    a_r10_slave_silent: assert property (@(posedge clk) disable iff (rst)
        !master_i |-> (!l_busy_o && !r_busy_o));

    a_r9_left_dark: assert property (@(posedge clk) disable iff (rst)
        !(l_ce && l_oe && !l_we) |=> (l_rdata == '0));

    a_r9_right_dark: assert property (@(posedge clk) disable iff (rst)
        !(r_ce && r_oe && !r_we) |=> (r_rdata == '0));
endmodule

bind dual_port_arb_ram dpr_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .master_i (master_i),
    .l_ce     (l_ce),
    .l_we     (l_we),
    .l_oe     (l_oe),
    .l_addr   (l_addr),
    .l_rdata  (l_rdata),
    .l_busy_o (l_busy_o),
    .r_ce     (r_ce),
    .r_we     (r_we),
    .r_oe     (r_oe),
    .r_addr   (r_addr),
    .r_rdata  (r_rdata),
    .r_busy_o (r_busy_o)
);

// File: tb/tb_dual_port_arb_ram.sv
`timescale 1ns/100ps
module tb_dual_port_arb_ram;
    logic        clk = 1'b0;
    logic        rst;
    logic        master_i;
    logic        l_ce, l_we, l_oe, l_busy_i;
    logic [12:0] l_addr;
    logic [8:0]  l_wdata;
    logic [8:0]  l_rdata;
    logic        l_busy_o;
    logic        r_ce, r_we, r_oe, r_busy_i;
    logic [12:0] r_addr;
    logic [8:0]  r_wdata;
    logic [8:0]  r_rdata;
    logic        r_busy_o;

    always #2.5 clk = ~clk;

    dual_port_arb_ram dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    logic [8:0] ref_mem [int];
    bit         pa_l = 0, pb_l = 0, pa_r = 0, pb_r = 0;
    int         pad_l = 0, pad_r = 0;
    bit         eb_l, eb_r;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic step(string tag,
                        bit lce, bit lwe, bit loe, int la, int ld,
                        bit rce, bit rwe, bit roe, int ra, int rd,
                        bit lbi = 0, bit rbi = 0);
        bit hit, hl, hr, ll, lr, bl, br;
        int xl, xr;
        @(negedge clk);
        l_ce = lce; l_we = lwe; l_oe = loe; l_addr = la[12:0]; l_wdata = ld[8:0];
        r_ce = rce; r_we = rwe; r_oe = roe; r_addr = ra[12:0]; r_wdata = rd[8:0];
        l_busy_i = lbi; r_busy_i = rbi;
        #0.5;
        hit = lce && rce && (la == ra) && (lwe || rwe);
        hl  = lce && pa_l && !pb_l && (la == pad_l);
        hr  = rce && pa_r && !pb_r && (ra == pad_r);
        ll  = hit && hr && !hl;
        lr  = hit && !ll;
        eb_l = master_i && ll;
        eb_r = master_i && lr;
        bl = master_i ? ll : lbi;
        br = master_i ? lr : rbi;
        chk({tag, " left busy"},  int'(l_busy_o), int'(eb_l));
        chk({tag, " right busy"}, int'(r_busy_o), int'(eb_r));
        @(posedge clk);
        #0.5;
        xl = (lce && !lwe && loe) ? int'(ref_mem[la]) : 0;
        xr = (rce && !rwe && roe) ? int'(ref_mem[ra]) : 0;
        if (rce && rwe && !br) ref_mem[ra] = rd[8:0];
        if (lce && lwe && !bl) ref_mem[la] = ld[8:0];
        pa_l = lce; pb_l = bl; pad_l = la;
        pa_r = rce; pb_r = br; pad_r = ra;
        chk({tag, " left rdata"},  int'(l_rdata), xl);
        chk({tag, " right rdata"}, int'(r_rdata), xr);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1; master_i = 1;
        l_ce = 0; l_we = 0; l_oe = 0; l_addr = '0; l_wdata = '0; l_busy_i = 0;
        r_ce = 0; r_we = 0; r_oe = 0; r_addr = '0; r_wdata = '0; r_busy_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #0.5;
        chk("R1 reset left rdata",  int'(l_rdata),  0);
        chk("R1 reset right rdata", int'(r_rdata),  0);
        chk("R1 reset left busy",   int'(l_busy_o), 0);
        chk("R1 reset right busy",  int'(r_busy_o), 0);

        // R2 independent writes then cross reads
        step("R2 write",  1,1,1,  5,'h1AB, 1,1,1,  9,'h055);
        step("R2 read",   1,0,1,  9,0,     1,0,1,  5,0);
        // R3 shared read
        step("R3 shared", 1,0,1,  5,0,     1,0,1,  5,0);
        // R4 simultaneous write clash, R6 right write dropped
        step("R4 tie",    1,1,1, 20,'h133, 1,1,1, 20,'h0CC);
        step("R6 verify", 1,0,1, 20,0,     1,0,1, 20,0);
        // R8 idle right, R9 no output enable
        step("R8 idle",   1,1,1, 30,'h111, 0,1,1, 30,'h1FF);
        step("R9 oe low", 1,0,0, 30,0,     0,0,0,  0,0);
        // R5 right holds the word, left arrives late
        step("R5 hold",   0,0,0,  0,0,     1,0,1, 30,0);
        step("R5 late",   1,0,1, 30,0,     1,1,1, 30,'h0F0);
        step("R7 keep",   1,0,1, 30,0,     1,1,1, 30,'h0AA);
        step("R3 after",  1,0,1, 30,0,     1,0,1, 30,0);
        // R8 idle left cannot block right on same word
        step("R8 left off", 0,1,1, 30,'h1EE, 1,1,1, 30,'h077);
        step("R2 back",   1,0,1, 30,0,     0,0,0,  0,0);
        // R10 slave mode
        master_i = 1'b0;
        step("R10 blockL", 1,1,1, 40,'h101, 1,1,1, 40,'h0BE, 1, 0);
        step("R10 read",   1,0,1, 40,0,     1,0,1, 40,0,     0, 1);
        step("R10 clash",  1,1,1, 41,'h022, 1,1,1, 42,'h033, 0, 0);
        step("R10 check",  1,0,1, 42,0,     1,0,1, 41,0,     0, 0);
        step("R9 write",   1,1,1, 43,'h1C3, 0,0,0,  0,0);
        step("R9 idle",    0,0,0,  0,0,     0,0,0,  0,0);
        summary();
    end
endmodule